// File: doc/BRIEF.md
# Interrupt request priority resolver

This block watches eight interrupt request lines and decides, every cycle, whether one of them should interrupt the processor and which one. Each line is captured into a request register either as a level (the request copies the input) or as a rising edge (the request latches on a low-to-high change and holds until acknowledged). A mask register hides lines from arbitration. An in-service register records the lines the processor is currently handling.

Arbitration uses a rotating priority base: relative rank p belongs to line (p + base) mod 8, and rank 0 is the highest. The best unmasked pending line is offered only when its rank is strictly better than the best in-service rank, so a handler is interrupted only by something more urgent. A nesting mode can leave the cascade line out of the in-service ranking. The processor side drives an acknowledge strobe, a non-specific end-of-interrupt strobe, a base load and a set of mode inputs (automatic end-of-interrupt, rotate on automatic end-of-interrupt, nesting exclusion). Bus decoding, cascading of several controllers and vector formation belong to the surrounding logic.

Top module: `irq_prio_resolver`

## Requirements
- R1: A synchronous reset clears request, last-sampled level, in-service, mask and priority base to zero, so `irq_valid` is 0 after reset; the trigger-select register keeps its value through reset.
- R2: A line whose trigger-select bit is 1 (level) has a request bit that follows its input; when the input drops, the request is gone one cycle later.
- R3: A line whose trigger-select bit is 0 (edge) sets its request only when the input is 1 and was 0 at the previous clock; a later fall of the input leaves the request pending.
- R4: A line whose mask bit is 1 is never offered; clearing the mask bit offers a still-pending request.
- R5: The offered line is the pending, unmasked line with the lowest relative rank p, where rank p maps to line (p + base) mod 8; `rot_load` loads the base from `rot_base`.
- R6: `irq_valid` is 1 only when the best pending rank is strictly smaller than the best in-service rank (an empty set ranks 8); an equal or worse rank is held back.
- R7: With `nest_excl` set, in-service bit 2 (the cascade line) is left out of the in-service ranking.
- R8: An acknowledge while `irq_valid` is 1 and `auto_eoi` is 0 sets the in-service bit of the offered line.
- R9: An acknowledge with `auto_eoi` set leaves the in-service register unchanged; if `rot_on_aeoi` is also set, the base becomes (offered line + 1) mod 8.
- R10: An acknowledge clears the request bit of the offered line only when that line is in edge mode; a level request stays while its input is high.
- R11: `eoi_clr` clears the in-service bit of best rank (full in-service set, current base).
- R12: An acknowledge while `irq_valid` is 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Interrupt request inputs |
| trig_wr | input | 1 | Load trigger-select register from `trig_data` |
| trig_data | input | 8 | Trigger select per line, 1 = level, 0 = edge |
| mask_wr | input | 1 | Load mask register from `mask_data` |
| mask_data | input | 8 | Mask per line, 1 = hidden |
| ack | input | 1 | Acknowledge of the offered line |
| eoi_clr | input | 1 | Non-specific end of interrupt |
| rot_load | input | 1 | Load the priority base |
| rot_base | input | 3 | New priority base |
| auto_eoi | input | 1 | Mode: acknowledge does not enter in-service |
| rot_on_aeoi | input | 1 | Mode: rotate base on automatic end of interrupt |
| nest_excl | input | 1 | Mode: drop line 2 from the in-service ranking |
| irq_valid | output | 1 | An interrupt is offered |
| irq_index | output | 3 | Line number of the offered interrupt |

## Verification
Every register update lands on the rising edge that samples the stimulus, and `irq_valid`/`irq_index` are combinational from the registers, so each result is due one edge after its stimulus; the mode inputs act in the same cycle with no edge at all. The bench drives on the falling edge and compares on the next falling edge, exactly one register stage later. The in-service register is not visible at the ports, so its content is judged by which later requests get through or are held back, with line choices picked so that a wrong bit changes the outcome.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    // Trigger-select encoding per line
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/irqp_scan.sv
// Rotating-priority scan: rank p looks at line (p + base) mod NLINES.
module irqp_scan #(
    parameter int NLINES = 8,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] vec,
    input  logic [IDX_W-1:0]  base,
    output logic              hit,
    output logic [IDX_W:0]    rank,
    output logic [IDX_W-1:0]  line
);

    logic [IDX_W-1:0] li;

    always_comb begin
        hit  = 1'b0;
        rank = (IDX_W+1)'(NLINES);
        line = '0;
        li   = '0;
        // descending walk so the lowest rank is the last one kept
        for (int p = NLINES - 1; p >= 0; p--) begin
            li = IDX_W'(p) + base;
            if (vec[li]) begin
                hit  = 1'b1;
                rank = (IDX_W+1)'(p);
                line = li;
            end
        end
    end

endmodule

// File: rtl/irqp_req.sv
// Per-line request capture with edge or level trigger.
module irqp_req #(
    parameter int NLINES = 8,
    localparam int IDX_W = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] irq_in,
    input  logic [NLINES-1:0] trig_sel,
    input  logic [NLINES-1:0] req_q,
    input  logic [NLINES-1:0] last_q,
    input  logic              take,
    input  logic [IDX_W-1:0]  take_line,
    output logic [NLINES-1:0] req_d,
    output logic [NLINES-1:0] last_d
);
    import irqp_pkg::*;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic is_level;
        logic ack_clr;
        logic rise;
        assign is_level  = (trig_sel[i] == TRIG_LEVEL);
        assign ack_clr   = take && (take_line == IDX_W'(i));
        assign rise      = irq_in[i] && !last_q[i];
        assign req_d[i]  = is_level ? irq_in[i]
                                    : ((req_q[i] && !ack_clr) || rise);
        assign last_d[i] = irq_in[i];
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int NLINES       = 8,
    parameter int CASCADE_LINE = 2,
    localparam int IDX_W       = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_in,
    input  logic              trig_wr,
    input  logic [NLINES-1:0] trig_data,
    input  logic              mask_wr,
    input  logic [NLINES-1:0] mask_data,
    input  logic              ack,
    input  logic              eoi_clr,
    input  logic              rot_load,
    input  logic [IDX_W-1:0]  rot_base,
    input  logic              auto_eoi,
    input  logic              rot_on_aeoi,
    input  logic              nest_excl,
    output logic              irq_valid,
    output logic [IDX_W-1:0]  irq_index
);

    typedef struct packed {
        logic [NLINES-1:0] req;
        logic [NLINES-1:0] last;
        logic [NLINES-1:0] isr;
        logic [NLINES-1:0] mask;
        logic [NLINES-1:0] trig;
        logic [IDX_W-1:0]  base;
    } state_t;

    state_t state_d, state_q;

    logic [NLINES-1:0] pend_vec;
    logic [NLINES-1:0] isr_view;
    logic              pend_hit;
    logic [IDX_W:0]    pend_rank;
    logic [IDX_W-1:0]  pend_line;
    logic              isv_hit;
    logic [IDX_W:0]    isv_rank;
    logic [IDX_W-1:0]  isv_line;
    logic              isf_hit;
    logic [IDX_W:0]    isf_rank;
    logic [IDX_W-1:0]  isf_line;
    logic              take;
    logic [NLINES-1:0] req_nx;
    logic [NLINES-1:0] last_nx;

    // views of the state for the bound checker
    logic [NLINES-1:0] req_vec;
    logic [NLINES-1:0] isr_vec;
    logic [NLINES-1:0] mask_vec;
    logic [IDX_W-1:0]  base_val;

    assign req_vec  = state_q.req;
    assign isr_vec  = state_q.isr;
    assign mask_vec = state_q.mask;
    assign base_val = state_q.base;

    assign pend_vec = state_q.req & ~state_q.mask;

    always_comb begin
        isr_view = state_q.isr;
        if (nest_excl) begin
            isr_view[CASCADE_LINE] = 1'b0;
        end
    end

    irqp_scan #(.NLINES(NLINES)) u_scan_pend (
        .vec  (pend_vec),
        .base (state_q.base),
        .hit  (pend_hit),
        .rank (pend_rank),
        .line (pend_line)
    );

    irqp_scan #(.NLINES(NLINES)) u_scan_isv (
        .vec  (isr_view),
        .base (state_q.base),
        .hit  (isv_hit),
        .rank (isv_rank),
        .line (isv_line)
    );

    irqp_scan #(.NLINES(NLINES)) u_scan_isf (
        .vec  (state_q.isr),
        .base (state_q.base),
        .hit  (isf_hit),
        .rank (isf_rank),
        .line (isf_line)
    );

    assign irq_valid = pend_hit && (pend_rank < isv_rank);
    assign irq_index = pend_line;
    assign take      = ack && irq_valid;

    irqp_req #(.NLINES(NLINES)) u_req (
        .irq_in    (irq_in),
        .trig_sel  (state_q.trig),
        .req_q     (state_q.req),
        .last_q    (state_q.last),
        .take      (take),
        .take_line (pend_line),
        .req_d     (req_nx),
        .last_d    (last_nx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.req  = req_nx;
        state_d.last = last_nx;

        if (eoi_clr && isf_hit) begin
            state_d.isr[isf_line] = 1'b0;
        end
        if (take && !auto_eoi) begin
            state_d.isr[pend_line] = 1'b1;
        end

        if (rot_load) begin
            state_d.base = rot_base;
        end else if (take && auto_eoi && rot_on_aeoi) begin
            state_d.base = pend_line + 1'b1;
        end

        if (mask_wr) begin
            state_d.mask = mask_data;
        end
        if (trig_wr) begin
            state_d.trig = trig_data;
        end

        if (rst) begin
            state_d.req  = '0;
            state_d.last = '0;
            state_d.isr  = '0;
            state_d.mask = '0;
            state_d.base = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

endmodule

// File: rtl/irqp_chk.sv
module irqp_chk #(
    parameter int NLINES = 8,
    localparam int IDX_W = $clog2(NLINES)
) (
    input logic              clk,
    input logic              rst,
    input logic              ack,
    input logic              eoi_clr,
    input logic              rot_load,
    input logic              auto_eoi,
    input logic              rot_on_aeoi,
    input logic              nest_excl,
    input logic              irq_valid,
    input logic [IDX_W-1:0]  irq_index,
    input logic [NLINES-1:0] req_vec,
    input logic [NLINES-1:0] isr_vec,
    input logic [NLINES-1:0] mask_vec,
    input logic [IDX_W-1:0]  base_val
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (req_vec == '0 && isr_vec == '0 && mask_vec == '0 && base_val == '0));

    // R4
    offer_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (!mask_vec[irq_index] && req_vec[irq_index]));

    // R6
    offer_not_in_service_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !nest_excl) |-> !isr_vec[irq_index]);

    // R8
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_valid && !auto_eoi && !eoi_clr) |=> isr_vec[$past(irq_index)]);

    // R9
    aeoi_rotate_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_valid && auto_eoi && rot_on_aeoi && !rot_load)
        |=> (base_val == IDX_W'($past(irq_index) + 1'b1)));

    // R9
    aeoi_no_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && auto_eoi && !eoi_clr) |=> $stable(isr_vec));

    // R12
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !irq_valid && !eoi_clr && !rot_load) |=> ($stable(isr_vec) && $stable(base_val)));

endmodule

bind irq_prio_resolver irqp_chk #(.NLINES(NLINES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack         (ack),
    .eoi_clr     (eoi_clr),
    .rot_load    (rot_load),
    .auto_eoi    (auto_eoi),
    .rot_on_aeoi (rot_on_aeoi),
    .nest_excl   (nest_excl),
    .irq_valid   (irq_valid),
    .irq_index   (irq_index),
    .req_vec     (req_vec),
    .isr_vec     (isr_vec),
    .mask_vec    (mask_vec),
    .base_val    (base_val)
);

// File: tb/irq_prio_resolver_test.sv
module irq_prio_resolver_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_in = '0;
    logic       trig_wr = 1'b0;
    logic [7:0] trig_data = '0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_data = '0;
    logic       ack = 1'b0;
    logic       eoi_clr = 1'b0;
    logic       rot_load = 1'b0;
    logic [2:0] rot_base = '0;
    logic       auto_eoi = 1'b0;
    logic       rot_on_aeoi = 1'b0;
    logic       nest_excl = 1'b0;
    logic       irq_valid;
    logic [2:0] irq_index;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_prio_resolver uut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .trig_wr(trig_wr), .trig_data(trig_data),
        .mask_wr(mask_wr), .mask_data(mask_data),
        .ack(ack), .eoi_clr(eoi_clr),
        .rot_load(rot_load), .rot_base(rot_base),
        .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .nest_excl(nest_excl),
        .irq_valid(irq_valid), .irq_index(irq_index)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic v_exp, input logic [2:0] i_exp);
        checks++;
        if (irq_valid !== v_exp || (v_exp && irq_index !== i_exp)) begin
            failures++;
            $display("FAIL %s: valid=%0b index=%0d expected valid=%0b index=%0d",
                     tag, irq_valid, irq_index, v_exp, i_exp);
        end
    endtask

    task automatic pulse(input logic [7:0] bits);
        irq_in = irq_in | bits;
        step();
        irq_in = irq_in & ~bits;
    endtask

    task automatic do_ack(input logic aeoi);
        auto_eoi = aeoi;
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi_clr = 1'b1;
        step();
        eoi_clr = 1'b0;
    endtask

    task automatic load_base(input logic [2:0] b);
        rot_load = 1'b1;
        rot_base = b;
        step();
        rot_load = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        trig_wr = 1'b1;
        trig_data = 8'b0100_0000;   // line 6 level, rest edge
        step(); step();
        trig_wr = 1'b0;
        rst = 1'b0;
        expect_out("R1 reset state", 1'b0, 3'd0);
    endtask

    task automatic t_edge();
        irq_in[4] = 1'b1;
        step();
        expect_out("R3 rising edge latches", 1'b1, 3'd4);
        irq_in[4] = 1'b0;
        step();
        expect_out("R3 fall keeps request", 1'b1, 3'd4);
        do_ack(1'b1);
        expect_out("R10 edge request cleared by ack", 1'b0, 3'd0);
        pulse(8'h20);
        expect_out("R9 auto-eoi leaves no in-service", 1'b1, 3'd5);
        do_ack(1'b1);
        expect_out("R10 line 5 cleared", 1'b0, 3'd0);
    endtask

    task automatic t_level();
        irq_in[6] = 1'b1;
        step();
        expect_out("R2 level request follows input", 1'b1, 3'd6);
        do_ack(1'b1);
        expect_out("R10 level request stays after ack", 1'b1, 3'd6);
        irq_in[6] = 1'b0;
        step();
        expect_out("R2 level request drops with input", 1'b0, 3'd0);
    endtask

    task automatic t_mask();
        mask_wr = 1'b1; mask_data = 8'h08;
        step();
        mask_wr = 1'b0;
        pulse(8'h08);
        step();
        expect_out("R4 masked line hidden", 1'b0, 3'd0);
        mask_wr = 1'b1; mask_data = 8'h00;
        step();
        mask_wr = 1'b0;
        expect_out("R4 unmask offers pending", 1'b1, 3'd3);
        do_ack(1'b1);
        expect_out("R4 cleanup", 1'b0, 3'd0);
    endtask

    task automatic t_prio();
        pulse(8'h22);
        expect_out("R5 base 0 picks line 1", 1'b1, 3'd1);
        load_base(3'd4);
        expect_out("R5 base 4 picks line 5", 1'b1, 3'd5);
        load_base(3'd2);
        expect_out("R5 base 2 picks line 5", 1'b1, 3'd5);
        load_base(3'd6);
        expect_out("R5 base 6 wraps to line 1", 1'b1, 3'd1);
        do_ack(1'b1);
        do_ack(1'b1);
        expect_out("R5 both cleared", 1'b0, 3'd0);
        load_base(3'd0);
    endtask

    task automatic t_isr();
        pulse(8'h08);
        do_ack(1'b0);
        expect_out("R8 line 3 in service", 1'b0, 3'd0);
        pulse(8'h20);
        expect_out("R6 lower rank held back", 1'b0, 3'd0);
        pulse(8'h02);
        expect_out("R6 higher rank preempts", 1'b1, 3'd1);
        do_ack(1'b0);
        pulse(8'h04);
        expect_out("R8 line 1 in service blocks line 2", 1'b0, 3'd0);
        do_eoi();
        expect_out("R11 eoi clears best in-service", 1'b1, 3'd2);
        do_ack(1'b0);
        do_eoi();
        do_eoi();
        expect_out("R11 in-service emptied", 1'b1, 3'd5);
        do_ack(1'b1);
        expect_out("R11 cleanup", 1'b0, 3'd0);
    endtask

    task automatic t_nest();
        pulse(8'h04);
        do_ack(1'b0);
        pulse(8'h10);
        expect_out("R6 line 4 blocked by line 2", 1'b0, 3'd0);
        nest_excl = 1'b1;
        step();
        expect_out("R7 cascade excluded from ranking", 1'b1, 3'd4);
        do_ack(1'b1);
        nest_excl = 1'b0;
        do_eoi();
        expect_out("R7 cleanup", 1'b0, 3'd0);
    endtask

    task automatic t_rot_aeoi();
        rot_on_aeoi = 1'b1;
        pulse(8'h09);
        expect_out("R9 base 0 picks line 0", 1'b1, 3'd0);
        do_ack(1'b1);
        pulse(8'h01);
        expect_out("R9 base rotated to 1", 1'b1, 3'd3);
        do_ack(1'b1);
        expect_out("R9 line 0 after rotation", 1'b1, 3'd0);
        do_ack(1'b1);
        rot_on_aeoi = 1'b0;
        load_base(3'd0);
        expect_out("R9 cleanup", 1'b0, 3'd0);
    endtask

    task automatic t_idle_ack();
        do_ack(1'b0);
        pulse(8'h80);
        expect_out("R12 idle ack left no in-service", 1'b1, 3'd7);
        do_ack(1'b1);
        expect_out("R12 cleanup", 1'b0, 3'd0);
    endtask

    task automatic t_trig_kept();
        irq_in[6] = 1'b1;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        expect_out("R1 reset clears request", 1'b0, 3'd0);
        step();
        expect_out("R1 level request after reset", 1'b1, 3'd6);
        irq_in[6] = 1'b0;
        step();
        expect_out("R1 trigger select kept through reset", 1'b0, 3'd0);
    endtask

    initial begin
        step();
        t_reset();
        t_edge();
        t_level();
        t_mask();
        t_prio();
        t_isr();
        t_nest();
        t_rot_aeoi();
        t_idle_ack();
        t_trig_kept();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule